// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps an SDR SDRAM refreshed on behalf of a memory controller. An internal interval timer adds refresh credits to a small saturating counter. While credits are pending, the block raises `refresh_req`. It then waits until the controller answers with `banks_idle`, which means every bank is precharged and the command bus is released. Only then does it take the bus. It drives one auto-refresh command and keeps the bus for the full tRFC window of NOPs.

The block also handles low-power retention. When `lp_req` is high it takes the bus the same way and issues a burst of auto-refreshes. It then issues the self-refresh entry command and holds the clock enable low until `lp_req` falls. On exit it raises the clock enable and waits out tRFC with NOPs. A second burst of auto-refreshes follows before the bus is handed back.

The timings are parameters in picoseconds and are converted to clock cycles during elaboration. The tRFC window is rounded up to whole cycles. The refresh interval is rounded down to whole cycles.

Top module: `rfsh_seq`

## Requirements
- R1: After synchronous reset, `sdr_cke` is 1, the command pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), and `busy` and `refresh_req` are 0.
- R2: An auto-refresh is {cs_n,ras_n,cas_n,we_n} = 4'b0001 with `sdr_cke` high. It is only started from idle in the cycle after `banks_idle` was sampled high while a request was pending. It is only driven when `sdr_cke` was high in the previous cycle.
- R3: Every auto-refresh is followed by exactly TRFC_CYC = ceil(TRFC_PS / CLK_PERIOD_PS) NOP cycles with `busy` high, before the next command or the release of the bus.
- R4: One refresh credit is added every REFI_CYC = floor(REFI_PS / CLK_PERIOD_PS) clock cycles after reset. `refresh_req` is high exactly when the block is idle and either a credit is pending or `lp_req` is high.
- R5: Pending credits saturate at PEND_MAX (8). Each issued auto-refresh removes one credit. A credit is never removed below zero. A credit and a refresh in the same cycle cancel out. Credits that build up while the banks are busy are not lost.
- R6: A low-power sequence issues BURST_LEN auto-refreshes, each with its tRFC window. It then drives one cycle of self-refresh entry: the auto-refresh encoding with `sdr_cke` low. Once started, the sequence runs to entry even if `lp_req` falls.
- R7: After entry, `sdr_cke` stays low, the pins carry NOP and `busy` stays high for as long as `lp_req` is high.
- R8: When `lp_req` is low during self-refresh, `sdr_cke` rises in the next cycle. TRFC_CYC NOP cycles with `sdr_cke` high follow. Then BURST_LEN auto-refreshes, each with its tRFC window, are issued, and the block returns to idle.
- R9: If `lp_req` rises during a single refresh, the low-power sequence waits. The tRFC window completes, the block spends one idle cycle, and it needs a fresh `banks_idle` grant.
- R10: Outside its own sequences the block drives NOP with `sdr_cke` high and `busy` low. Between two separate refreshes it spends at least one idle cycle.
- R11: When idle and granted, a high `lp_req` takes precedence over pending credits and starts the low-power sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| banks_idle | input | 1 | Controller grant: all banks precharged and bus released |
| lp_req | input | 1 | Level request to enter and remain in self-refresh |
| refresh_req | output | 1 | Block wants the command bus |
| busy | output | 1 | Block owns the command bus |
| sdr_cke | output | 1 | SDRAM clock enable |
| sdr_cs_n | output | 1 | SDRAM chip select, active low |
| sdr_ras_n | output | 1 | SDRAM row strobe, active low |
| sdr_cas_n | output | 1 | SDRAM column strobe, active low |
| sdr_we_n | output | 1 | SDRAM write enable, active low |

## Verification
The bench holds the grant off long enough for credits to pile past the limit. It then counts the refreshes that drain them. A counter that wraps instead of saturating would issue too few or too many. A low-power request is raised inside a tRFC window. A sequencer that chains straight into the entry burst, without returning to idle and waiting for a new grant, would show a command in what should be an idle cycle. The exit path is compared cycle by cycle. A window that is one cycle short, a burst of the wrong length, or a clock enable that rises with a command instead of a NOP shows up as a pin mismatch. A low-power request dropped mid-burst checks that entry still completes and is followed at once by a clean exit.

// File: rtl/rfsh_seq_pkg.sv
package rfsh_seq_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_cmd_t CMD_REFRESH = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AREF,
        ST_TRFC,
        ST_SRE,
        ST_SELF,
        ST_SRX
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_SINGLE,
        PH_PRE,
        PH_POST
    } burst_phase_t;

    function automatic int unsigned cycles_ceil(input int unsigned span_ps,
                                                input int unsigned period_ps);
        return (span_ps + period_ps - 1) / period_ps;
    endfunction

    // bits needed for a counter holding 0 .. n-1
    function automatic int unsigned bits_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rfsh_pend_tracker.sv
module rfsh_pend_tracker
    import rfsh_seq_pkg::*;
#(
    parameter int unsigned REFI_CYC = 780,
    parameter int unsigned PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ar_issued,
    output logic pend_nonzero
);
    localparam int unsigned TW = bits_for(REFI_CYC);
    localparam int unsigned PW = bits_for(PEND_MAX + 1);
    localparam logic [TW-1:0] TMR_LAST = TW'(REFI_CYC - 1);
    localparam logic [PW-1:0] PEND_TOP = PW'(PEND_MAX);

    logic [TW-1:0] tmr_q;
    logic [PW-1:0] pend_q, pend_d;
    logic          tick;

    assign tick = (tmr_q == TMR_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else if (tick) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    always_comb begin
        pend_d = pend_q;
        unique case ({tick, ar_issued})
            2'b10:   if (pend_q != PEND_TOP) pend_d = pend_q + 1'b1;
            2'b01:   if (pend_q != '0)       pend_d = pend_q - 1'b1;
            default: pend_d = pend_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign pend_nonzero = (pend_q != '0);

    // R5: credit count never exceeds its ceiling
    p_pend_ceiling_r5: assert property (@(posedge clk) disable iff (rst)
        pend_q <= PEND_TOP);

    // R5: a refresh without a tick consumes exactly one credit
    p_pend_consume_r5: assert property (@(posedge clk) disable iff (rst)
        (ar_issued && !tick && pend_q != '0) |=> (pend_q == $past(pend_q) - 1'b1));

endmodule

// File: rtl/rfsh_seq_fsm.sv
module rfsh_seq_fsm
    import rfsh_seq_pkg::*;
#(
    parameter int unsigned TRFC_CYC  = 4,
    parameter int unsigned BURST_LEN = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       banks_idle,
    input  logic       lp_req,
    input  logic       pend_nonzero,
    output seq_state_t state
);
    localparam int unsigned CW = bits_for(TRFC_CYC);
    localparam int unsigned BW = bits_for(BURST_LEN);
    localparam logic [CW-1:0] WIN_LAST   = CW'(TRFC_CYC - 1);
    localparam logic [BW-1:0] BURST_LAST = BW'(BURST_LEN - 1);

    seq_state_t    st_q, st_d;
    burst_phase_t  ph_q, ph_d;
    logic [CW-1:0] win_q, win_d;
    logic [BW-1:0] left_q, left_d;

    always_comb begin
        st_d   = st_q;
        ph_d   = ph_q;
        win_d  = win_q;
        left_d = left_q;
        unique case (st_q)
            ST_IDLE: begin
                if (banks_idle && (lp_req || pend_nonzero)) begin
                    st_d = ST_AREF;
                    if (lp_req) begin
                        ph_d   = PH_PRE;
                        left_d = BURST_LAST;
                    end else begin
                        ph_d   = PH_SINGLE;
                        left_d = '0;
                    end
                end
            end
            ST_AREF: begin
                st_d  = ST_TRFC;
                win_d = WIN_LAST;
            end
            ST_TRFC: begin
                if (win_q != '0) begin
                    win_d = win_q - 1'b1;
                end else if (left_q != '0) begin
                    left_d = left_q - 1'b1;
                    st_d   = ST_AREF;
                end else if (ph_q == PH_PRE) begin
                    st_d = ST_SRE;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_SRE: begin
                st_d = ST_SELF;
            end
            ST_SELF: begin
                if (!lp_req) begin
                    st_d  = ST_SRX;
                    win_d = WIN_LAST;
                end
            end
            ST_SRX: begin
                if (win_q != '0) begin
                    win_d = win_q - 1'b1;
                end else begin
                    st_d   = ST_AREF;
                    ph_d   = PH_POST;
                    left_d = BURST_LAST;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ph_q   <= PH_SINGLE;
            win_q  <= '0;
            left_q <= '0;
        end else begin
            st_q   <= st_d;
            ph_q   <= ph_d;
            win_q  <= win_d;
            left_q <= left_d;
        end
    end

    assign state = st_q;

    // checker: length of each tRFC window after a refresh
    logic [CW:0] chk_run;
    always_ff @(posedge clk) begin
        if (rst)                   chk_run <= '0;
        else if (st_q == ST_AREF)  chk_run <= '0;
        else if (st_q == ST_TRFC)  chk_run <= chk_run + 1'b1;
    end

    // R3: window closes only after TRFC_CYC NOP cycles
    p_trfc_window_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_TRFC && st_q != ST_TRFC) |-> (chk_run == (CW+1)'(TRFC_CYC)));

    // R7: self-refresh is held while the request stays high
    p_sr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SELF && lp_req) |=> (st_q == ST_SELF));

endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
    import rfsh_seq_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 20000,
    parameter int unsigned TRFC_PS       = 66000,
    parameter int unsigned REFI_PS       = 15600000,
    parameter int unsigned BURST_LEN     = 4096,
    parameter int unsigned PEND_MAX      = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic banks_idle,
    input  logic lp_req,
    output logic refresh_req,
    output logic busy,
    output logic sdr_cke,
    output logic sdr_cs_n,
    output logic sdr_ras_n,
    output logic sdr_cas_n,
    output logic sdr_we_n
);
    localparam int unsigned TRFC_CYC = cycles_ceil(TRFC_PS, CLK_PERIOD_PS);
    localparam int unsigned REFI_CYC = REFI_PS / CLK_PERIOD_PS;

    seq_state_t state;
    logic       pend_nonzero;
    logic       ar_issued;
    sdr_cmd_t   cmd;

    rfsh_pend_tracker #(
        .REFI_CYC (REFI_CYC),
        .PEND_MAX (PEND_MAX)
    ) u_pend (
        .clk          (clk),
        .rst          (rst),
        .ar_issued    (ar_issued),
        .pend_nonzero (pend_nonzero)
    );

    rfsh_seq_fsm #(
        .TRFC_CYC  (TRFC_CYC),
        .BURST_LEN (BURST_LEN)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .banks_idle   (banks_idle),
        .lp_req       (lp_req),
        .pend_nonzero (pend_nonzero),
        .state        (state)
    );

    assign ar_issued   = (state == ST_AREF);
    assign cmd         = (state == ST_AREF || state == ST_SRE) ? CMD_REFRESH : CMD_NOP;
    assign sdr_cke     = !(state == ST_SRE || state == ST_SELF);
    assign busy        = (state != ST_IDLE);
    assign refresh_req = (state == ST_IDLE) && (lp_req || pend_nonzero);

    assign sdr_cs_n  = cmd.cs_n;
    assign sdr_ras_n = cmd.ras_n;
    assign sdr_cas_n = cmd.cas_n;
    assign sdr_we_n  = cmd.we_n;

    sdr_cmd_t pin_cmd;
    assign pin_cmd = '{cs_n: sdr_cs_n, ras_n: sdr_ras_n, cas_n: sdr_cas_n, we_n: sdr_we_n};

    // R2: refresh only when the device was not powered down last cycle
    p_aref_prev_cke_r2: assert property (@(posedge clk) disable iff (rst)
        (pin_cmd == CMD_REFRESH && sdr_cke) |-> $past(sdr_cke));

    // R2: bus taken only after a grant to a raised request
    p_grant_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(banks_idle) && $past(refresh_req)));

    // R3: the cycle after a refresh is a NOP with the bus still held
    p_nop_after_aref_r3: assert property (@(posedge clk) disable iff (rst)
        (pin_cmd == CMD_REFRESH && sdr_cke) |=> (pin_cmd == CMD_NOP && busy));

    // R6: clock enable falls only with the self-refresh entry encoding
    p_sre_enc_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(sdr_cke) |-> (pin_cmd == CMD_REFRESH));

    // R8: clock enable rises with a NOP
    p_exit_nop_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(sdr_cke) |-> (pin_cmd == CMD_NOP && busy));

    // R4: request is only shown while idle
    p_req_idle_r4: assert property (@(posedge clk) disable iff (rst)
        refresh_req |-> !busy);

endmodule

// File: tb/rfsh_seq_tb_top.sv
`timescale 1ns/1ps
module rfsh_seq_tb_top;

    localparam int CLK_PS  = 20000;
    localparam int TRFC_PS = 66000;
    localparam int REFI_PS = 1000000;
    localparam int BURST   = 3;
    localparam int PMAX    = 8;
    localparam int TRFC_N  = (TRFC_PS + CLK_PS - 1) / CLK_PS;   // 4
    localparam int REFI_N  = REFI_PS / CLK_PS;                  // 50

    localparam int K_IDLE = 0;
    localparam int K_AR   = 1;
    localparam int K_NOP  = 2;
    localparam int K_SRE  = 3;
    localparam int K_SELF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic banks_idle = 1'b0;
    logic lp_req = 1'b0;
    logic refresh_req, busy, sdr_cke, sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n;

    always #10 clk = ~clk;

    rfsh_seq #(
        .CLK_PERIOD_PS (CLK_PS),
        .TRFC_PS       (TRFC_PS),
        .REFI_PS       (REFI_PS),
        .BURST_LEN     (BURST),
        .PEND_MAX      (PMAX)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .banks_idle  (banks_idle),
        .lp_req      (lp_req),
        .refresh_req (refresh_req),
        .busy        (busy),
        .sdr_cke     (sdr_cke),
        .sdr_cs_n    (sdr_cs_n),
        .sdr_ras_n   (sdr_ras_n),
        .sdr_cas_n   (sdr_cas_n),
        .sdr_we_n    (sdr_we_n)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model state
    int    kind_q[$];
    string tag_q[$];
    int    cur_kind = K_IDLE;
    string cur_tag  = "R10";
    int    m_timer  = 0;
    int    m_pend   = 0;

    bit count_en = 1'b0;
    int dut_ar_cnt = 0;
    int mdl_ar_cnt = 0;

    task automatic push_refresh(input string t_ar, input string t_win);
        kind_q.push_back(K_AR);
        tag_q.push_back(t_ar);
        for (int i = 0; i < TRFC_N; i++) begin
            kind_q.push_back(K_NOP);
            tag_q.push_back(t_win);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            kind_q.delete();
            tag_q.delete();
            cur_kind = K_IDLE;
            cur_tag  = "R1";
            m_timer  = 0;
            m_pend   = 0;
        end else begin
            bit ar_now;
            bit tick;
            int old_pend;
            ar_now   = (cur_kind == K_AR);
            tick     = (m_timer == REFI_N - 1);
            m_timer  = tick ? 0 : m_timer + 1;
            old_pend = m_pend;
            if (cur_kind == K_SELF) begin
                if (!lp_req) begin
                    for (int i = 0; i < TRFC_N; i++) begin
                        kind_q.push_back(K_NOP);
                        tag_q.push_back("R8");
                    end
                    for (int b = 0; b < BURST; b++) push_refresh("R8", "R8");
                    cur_kind = kind_q.pop_front();
                    cur_tag  = tag_q.pop_front();
                end
            end else if (kind_q.size() > 0) begin
                cur_kind = kind_q.pop_front();
                cur_tag  = tag_q.pop_front();
            end else if (cur_kind != K_IDLE) begin
                cur_kind = K_IDLE;
                cur_tag  = "R10";
            end else if (banks_idle && (lp_req || old_pend > 0)) begin
                if (lp_req) begin
                    for (int b = 0; b < BURST; b++)
                        push_refresh((old_pend > 0) ? "R11" : "R6", "R3/R6");
                    kind_q.push_back(K_SRE);
                    tag_q.push_back("R6");
                    kind_q.push_back(K_SELF);
                    tag_q.push_back("R7");
                end else begin
                    push_refresh("R2", "R3/R9");
                end
                cur_kind = kind_q.pop_front();
                cur_tag  = tag_q.pop_front();
            end else begin
                cur_kind = K_IDLE;
                cur_tag  = "R4/R10";
            end
            m_pend = old_pend + (tick ? 1 : 0) - (ar_now ? 1 : 0);
            if (m_pend > PMAX) m_pend = PMAX;
            if (m_pend < 0) m_pend = 0;
        end
    end

    // cycle compare, away from the active edge
    always @(posedge clk) begin
        #5;
        if (!rst && !done) begin
            logic [3:0] exp_cmd, act_cmd;
            logic       exp_cke, exp_busy, exp_req;
            exp_cmd  = (cur_kind == K_AR || cur_kind == K_SRE) ? 4'b0001 : 4'b0111;
            exp_cke  = !(cur_kind == K_SRE || cur_kind == K_SELF);
            exp_busy = (cur_kind != K_IDLE);
            exp_req  = (cur_kind == K_IDLE) && (lp_req || m_pend > 0);
            act_cmd  = {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n};
            n_checks++;
            if ({act_cmd, sdr_cke, busy, refresh_req} !== {exp_cmd, exp_cke, exp_busy, exp_req}) begin
                n_fail++;
                $display("FAIL %s t=%0t {cmd,cke,busy,req} actual=%b_%b_%b_%b expected=%b_%b_%b_%b",
                         cur_tag, $time, act_cmd, sdr_cke, busy, refresh_req,
                         exp_cmd, exp_cke, exp_busy, exp_req);
            end
            if (count_en) begin
                if (act_cmd == 4'b0001 && sdr_cke) dut_ar_cnt++;
                if (cur_kind == K_AR) mdl_ar_cnt++;
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #5;
        // R1: reset state
        n_checks++;
        if ({sdr_cke, sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n, busy, refresh_req} !== 7'b1_0111_00) begin
            n_fail++;
            $display("FAIL R1 reset pins actual=%b expected=%b",
                     {sdr_cke, sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n, busy, refresh_req}, 7'b1_0111_00);
        end

        // R4 / R2: credits accumulate while withheld, then drain on grant
        repeat (120) @(negedge clk);
        banks_idle = 1'b1;
        repeat (40) @(negedge clk);

        // R5: saturation after a long busy period
        banks_idle = 1'b0;
        repeat (650) @(negedge clk);
        count_en = 1'b1;
        banks_idle = 1'b1;
        repeat (48) @(negedge clk);
        count_en = 1'b0;
        n_checks++;
        if (dut_ar_cnt != mdl_ar_cnt || mdl_ar_cnt < PMAX) begin
            n_fail++;
            $display("FAIL R5 refreshes after saturation actual=%0d expected=%0d",
                     dut_ar_cnt, mdl_ar_cnt);
        end
        repeat (100) @(negedge clk);

        // R6 R7 R8: full low-power round trip
        lp_req = 1'b1;
        repeat (BURST * (TRFC_N + 1) + 30) @(negedge clk);
        lp_req = 1'b0;
        repeat (40) @(negedge clk);

        // R9: low-power request inside a single refresh window
        do @(negedge clk); while (!busy);
        @(negedge clk);
        lp_req = 1'b1;
        repeat (60) @(negedge clk);
        lp_req = 1'b0;
        repeat (40) @(negedge clk);

        // R11: low-power request wins over pending credits
        banks_idle = 1'b0;
        repeat (60) @(negedge clk);
        lp_req = 1'b1;
        repeat (3) @(negedge clk);
        banks_idle = 1'b1;
        repeat (40) @(negedge clk);
        lp_req = 1'b0;
        repeat (40) @(negedge clk);

        // R6: request dropped mid-burst still completes entry, then exits
        lp_req = 1'b1;
        repeat (3) @(negedge clk);
        lp_req = 1'b0;
        repeat (60) @(negedge clk);

        finish_run();
    end

endmodule